// File: doc/BRIEF.md
# Two-Channel Sequential Break Matcher

This block is a debug comparator that watches bus traffic and raises a break request to the core. It has two channels, A and B. Each channel compares one bus against a reference address under a bit mask, and filters the access by direction (read or write) and by kind (instruction fetch or data access). Two buses are observed: an instruction-side bus and an internal bus. A channel's configuration selects which one it watches, so a channel never looks at both in the same setting.

In independent mode a match on either channel raises the break request. In sequential mode a match on channel A only arms the unit. The break is raised by a channel B match in a later bus cycle. A cycle in which both channels match at once arms the unit and does not fire. Each channel also keeps a sticky condition-match flag that software reads and clears.

Software reaches the configuration through a small register port with a valid/ready handshake. Writes pass through a fixed two-stage delay before they reach the active copy, so the comparators go on using the old settings for a short time. A read is held off, with ready low, until every write already accepted has been applied. When a read completes, the value returned is therefore the updated one. Writes are always accepted at once.

Top module: `brk_seq_matcher`

## Requirements
- R1: A channel's address compare ignores every bit that is set in its mask register (offsets 1 for A, 4 for B). Every bit that is clear must equal the reference address (offsets 0 for A, 3 for B).
- R2: In a channel control register (offset 2 for A, 5 for B), bit 2 allows reads (write=0) and bit 3 allows writes (write=1). An access whose direction is not allowed never matches.
- R3: In the control register, bit 4 allows fetches (fetch=1) and bit 5 allows data accesses (fetch=0). A channel whose enable bit 0 is clear never matches.
- R4: Control bit 1 selects the watched bus: 0 is the instruction-side bus (ib_*) and 1 is the internal bus (db_*). Traffic on the other bus has no effect on that channel.
- R5: When mode register bit 0 (offset 6) is 0, a match on either channel drives brk_req high for exactly the one cycle after the bus cycle.
- R6: When mode bit 0 is 1, brk_req is raised in the cycle after a channel B match only if channel A matched in an earlier cycle and the unit is still armed. If A and B match in the same cycle while the unit is unarmed, it becomes armed and brk_req stays low.
- R7: The armed state is shown in status bit 2 (offset 7). It stays set until a break fires, until software writes 0 to status bit 2, or until the mode bit changes.
- R8: Status bits 0 and 1 are sticky match flags for A and B. Writing 0 to a bit clears it, and writing 1 has no effect. A clearing write that is applied in the same cycle as a hardware match wins.
- R9: A register write accepted at clock edge E reaches the active copy at edge E+2. Bus cycles sampled at E+1 and E+2 still use the old value.
- R10: A read (reg_valid=1, reg_we=0) keeps reg_ready low while any accepted write is pending. When it completes, reg_rdata returns the updated value. A read right after a single write stalls for 2 cycles. Writes are always ready.
- R11: After reset every register reads 0, brk_req is 0 and reg_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ib_valid | input | 1 | Instruction-side bus cycle present |
| ib_addr | input | AW | Instruction-side bus address |
| ib_write | input | 1 | Instruction-side bus direction, 1 = write |
| ib_fetch | input | 1 | Instruction-side bus kind, 1 = fetch |
| db_valid | input | 1 | Internal bus cycle present |
| db_addr | input | AW | Internal bus address |
| db_write | input | 1 | Internal bus direction, 1 = write |
| db_fetch | input | 1 | Internal bus kind, 1 = fetch |
| reg_valid | input | 1 | Register request valid |
| reg_we | input | 1 | Register request is a write |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_ready | output | 1 | Register request accepted this cycle |
| reg_rdata | output | AW | Read data, valid when a read is accepted |
| brk_req | output | 1 | One-cycle break request |

## Verification
The hardest state to reach from the ports is a clearing write to the status register that lands in the same clock edge as a hardware match. The write must be timed so that it comes out of the two-stage delay exactly when the matching bus cycle is sampled. The bench places the bus cycle two edges after the write is accepted. It does the same for the window in R9, where bus cycles in the two edges after a write still see the old address. Sequential behaviour is covered by sweeping every three-cycle pattern of {none, A, B, A and B together}, starting each pattern from the disarmed state. The expected break train comes from a small arithmetic model of the arming rule.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int unsigned NCH = 2;

  // control field layout, lsb first: en, bus select, dir qualifier, kind qualifier
  typedef struct packed {
    logic [1:0] kdq;   // bit0 fetch allowed, bit1 data allowed
    logic [1:0] rwq;   // bit0 read allowed, bit1 write allowed
    logic       bsel;  // 0 instruction-side bus, 1 internal bus
    logic       en;
  } chan_cfg_t;

  localparam int unsigned CFG_W = $bits(chan_cfg_t);

  localparam logic [2:0] OFS_A_ADDR = 3'd0;
  localparam logic [2:0] OFS_A_MASK = 3'd1;
  localparam logic [2:0] OFS_A_CTRL = 3'd2;
  localparam logic [2:0] OFS_B_ADDR = 3'd3;
  localparam logic [2:0] OFS_B_MASK = 3'd4;
  localparam logic [2:0] OFS_B_CTRL = 3'd5;
  localparam logic [2:0] OFS_MODE   = 3'd6;
  localparam logic [2:0] OFS_STAT   = 3'd7;
endpackage

// File: rtl/dbgm_regs.sv
module dbgm_regs
  import dbgm_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned WR_DELAY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_valid,
  input  logic                  reg_we,
  input  logic [2:0]            reg_addr,
  input  logic [AW-1:0]         reg_wdata,
  output logic                  reg_ready,
  output logic [AW-1:0]         reg_rdata,
  input  logic [2:0]            stat_in,
  output logic [NCH-1:0][AW-1:0] cmp_addr,
  output logic [NCH-1:0][AW-1:0] cmp_mask,
  output chan_cfg_t [NCH-1:0]   cfg,
  output logic                  seq_mode,
  output logic                  mode_chg,
  output logic                  stat_wr,
  output logic [2:0]            stat_wdata
);
  localparam int unsigned PW = 1 + 3 + AW;

  logic [PW-1:0] pipe_q [WR_DELAY];
  logic          pending;
  logic          ex_v;
  logic [2:0]    ex_a;
  logic [AW-1:0] ex_d;
  logic          seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WR_DELAY; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= {reg_valid & reg_we, reg_addr, reg_wdata};
      for (int i = 1; i < WR_DELAY; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  always_comb begin
    pending = 1'b0;
    for (int i = 0; i < WR_DELAY; i++) pending = pending | pipe_q[i][PW-1];
  end

  assign {ex_v, ex_a, ex_d} = pipe_q[WR_DELAY-1];
  assign reg_ready = reg_we | ~pending;

  for (genvar c = 0; c < NCH; c++) begin : g_creg
    localparam logic [2:0] BASE = 3'(3 * c);
    logic [AW-1:0] a_q, m_q;
    chan_cfg_t     k_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        m_q <= '0;
        k_q <= '0;
      end else if (ex_v) begin
        if (ex_a == BASE)        a_q <= ex_d;
        if (ex_a == BASE + 3'd1) m_q <= ex_d;
        if (ex_a == BASE + 3'd2) k_q <= chan_cfg_t'(ex_d[CFG_W-1:0]);
      end
    end
    assign cmp_addr[c] = a_q;
    assign cmp_mask[c] = m_q;
    assign cfg[c]      = k_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seq_q <= 1'b0;
    else if (ex_v && ex_a == OFS_MODE)   seq_q <= ex_d[0];
  end

  assign seq_mode   = seq_q;
  assign mode_chg   = ex_v && (ex_a == OFS_MODE) && (ex_d[0] != seq_q);
  assign stat_wr    = ex_v && (ex_a == OFS_STAT);
  assign stat_wdata = ex_d[2:0];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_A_ADDR: reg_rdata = cmp_addr[0];
      OFS_A_MASK: reg_rdata = cmp_mask[0];
      OFS_A_CTRL: reg_rdata = AW'(cfg[0]);
      OFS_B_ADDR: reg_rdata = cmp_addr[1];
      OFS_B_MASK: reg_rdata = cmp_mask[1];
      OFS_B_CTRL: reg_rdata = AW'(cfg[1]);
      OFS_MODE:   reg_rdata = AW'(seq_q);
      OFS_STAT:   reg_rdata = AW'(stat_in);
      default:    reg_rdata = '0;
    endcase
  end

  // R9: the active copy moves only when a write leaves the delay line
  a_r9_active_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_v |=> ($stable(cmp_addr) && $stable(cmp_mask) && $stable(cfg) && $stable(seq_mode)));

  // R10: an accepted read never overlaps a write still leaving the delay line
  a_r10_read_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_we && reg_ready) |-> !ex_v);
endmodule

// File: rtl/dbgm_chan.sv
module dbgm_chan
  import dbgm_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  chan_cfg_t     cfg,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] ref_mask,
  input  logic          ib_valid,
  input  logic [AW-1:0] ib_addr,
  input  logic          ib_write,
  input  logic          ib_fetch,
  input  logic          db_valid,
  input  logic [AW-1:0] db_addr,
  input  logic          db_write,
  input  logic          db_fetch,
  output logic          hit
);
  logic          s_v, s_w, s_f;
  logic [AW-1:0] s_a;
  logic          dir_ok, kind_ok, adr_ok;

  always_comb begin
    if (cfg.bsel) begin
      s_v = db_valid; s_a = db_addr; s_w = db_write; s_f = db_fetch;
    end else begin
      s_v = ib_valid; s_a = ib_addr; s_w = ib_write; s_f = ib_fetch;
    end
  end

  assign dir_ok  = s_w ? cfg.rwq[1] : cfg.rwq[0];
  assign kind_ok = s_f ? cfg.kdq[0] : cfg.kdq[1];
  assign adr_ok  = ((s_a ^ ref_addr) & ~ref_mask) == '0;
  assign hit     = cfg.en & s_v & dir_ok & kind_ok & adr_ok;
endmodule

// File: rtl/dbgm_seq.sv
module dbgm_seq
  import dbgm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           seq_mode,
  input  logic           mode_chg,
  input  logic           stat_wr,
  input  logic [2:0]     stat_wdata,
  output logic [2:0]     stat,
  output logic           brk_req
);
  logic           armed_q, brk_q;
  logic [NCH-1:0] flag_q;
  logic           fire, disarm;

  assign fire   = seq_mode ? (armed_q & hit[1]) : (|hit);
  assign disarm = mode_chg | (stat_wr & ~stat_wdata[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      brk_q <= fire;
      if (disarm || !seq_mode || fire) armed_q <= 1'b0;
      else if (hit[0])                 armed_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q[c] <= 1'b0;
      else if (stat_wr && !stat_wdata[c])  flag_q[c] <= 1'b0;
      else if (hit[c])                     flag_q[c] <= 1'b1;
    end
  end

  assign stat    = {armed_q, flag_q};
  assign brk_req = brk_q;

  a_r5_indep_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && |hit) |=> brk_req);

  a_r6_no_fire_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !armed_q) |=> !brk_req);

  a_r6_fire_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && armed_q && hit[1]) |=> brk_req);

  a_r7_arm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && armed_q && !hit[1] && !mode_chg && !(stat_wr && !stat_wdata[2])) |=> stat[2]);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !stat_wr) |=> stat[0]);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_wdata[0]) |=> !stat[0]);
endmodule

// File: rtl/brk_seq_matcher.sv
module brk_seq_matcher
  import dbgm_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned WR_DELAY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ib_valid,
  input  logic [AW-1:0] ib_addr,
  input  logic          ib_write,
  input  logic          ib_fetch,
  input  logic          db_valid,
  input  logic [AW-1:0] db_addr,
  input  logic          db_write,
  input  logic          db_fetch,
  input  logic          reg_valid,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic          reg_ready,
  output logic [AW-1:0] reg_rdata,
  output logic          brk_req
);
  logic [NCH-1:0][AW-1:0] cmp_addr, cmp_mask;
  chan_cfg_t [NCH-1:0]    cfg;
  logic                   seq_mode, mode_chg, stat_wr;
  logic [2:0]             stat_wdata, stat;
  logic [NCH-1:0]         hit;

  dbgm_regs #(.AW(AW), .WR_DELAY(WR_DELAY)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .stat_in(stat), .cmp_addr(cmp_addr), .cmp_mask(cmp_mask), .cfg(cfg),
    .seq_mode(seq_mode), .mode_chg(mode_chg),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dbgm_chan #(.AW(AW)) u_chan (
      .cfg(cfg[c]), .ref_addr(cmp_addr[c]), .ref_mask(cmp_mask[c]),
      .ib_valid(ib_valid), .ib_addr(ib_addr), .ib_write(ib_write), .ib_fetch(ib_fetch),
      .db_valid(db_valid), .db_addr(db_addr), .db_write(db_write), .db_fetch(db_fetch),
      .hit(hit[c])
    );
  end

  dbgm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .seq_mode(seq_mode), .mode_chg(mode_chg),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat(stat), .brk_req(brk_req)
  );

  // R3: a disabled channel leaves its flag untouched
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[0].en && !stat[0]) |=> !stat[0]);
endmodule

// File: tb/brk_seq_matcher_bench.sv
module brk_seq_matcher_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ib_valid = 0, ib_write = 0, ib_fetch = 0;
  logic db_valid = 0, db_write = 0, db_fetch = 0;
  logic [AW-1:0] ib_addr = '0, db_addr = '0;
  logic reg_valid = 0, reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic reg_ready;
  logic [AW-1:0] reg_rdata;
  logic brk_req;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  brk_seq_matcher #(.AW(AW)) u_brk_seq_matcher (
    .clk(clk), .rst_n(rst_n),
    .ib_valid(ib_valid), .ib_addr(ib_addr), .ib_write(ib_write), .ib_fetch(ib_fetch),
    .db_valid(db_valid), .db_addr(db_addr), .db_write(db_write), .db_fetch(db_fetch),
    .reg_valid(reg_valid), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .brk_req(brk_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    reg_valid = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int d, output int stalls);
    reg_valid = 1; reg_we = 0; reg_addr = a;
    stalls = 0;
    #1;
    while (!reg_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    d = int'(reg_rdata);
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input logic iv, input logic [AW-1:0] ia, input logic iw, input logic ifc,
                     input logic dv, input logic [AW-1:0] da, input logic dw, input logic dfc,
                     output int b);
    ib_valid = iv; ib_addr = ia; ib_write = iw; ib_fetch = ifc;
    db_valid = dv; db_addr = da; db_write = dw; db_fetch = dfc;
    @(negedge clk);
    b = int'(brk_req);
    ib_valid = 0; db_valid = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int d, st, b, armed, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk("R11 brk", int'(brk_req), 0);
    chk("R11 ready", int'(reg_ready), 1);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d, st);
      chk("R11 reg zero", d, 0);
    end

    // R2 / R3 qualifier sweep on channel A, instruction-side bus
    wr(3'd0, 16'h1234);
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k < 4; k++) begin
        wr(3'd2, 16'((k << 4) | (q << 2) | 1));
        idle(3);
        for (int w = 0; w < 2; w++) begin
          for (int f = 0; f < 2; f++) begin
            bus(1, 16'h1234, w[0], f[0], 0, 0, 0, 0, b);
            exp = ((q >> w) & 1) & (f != 0 ? (k & 1) : ((k >> 1) & 1));
            chk("R2/R3 qualifier", b, exp);
          end
        end
      end
    end
    // R3 disabled channel
    wr(3'd7, 16'h0); wr(3'd2, 16'h003C); idle(3);
    for (int w = 0; w < 2; w++) begin
      bus(1, 16'h1234, w[0], 1'b0, 0, 0, 0, 0, b);
      chk("R3 disabled brk", b, 0);
    end
    rd(3'd7, d, st);
    chk("R3 disabled flag", d & 1, 0);

    // R1 mask sweep
    wr(3'd2, 16'h003D); wr(3'd0, 16'h1200); wr(3'd1, 16'h00F0); idle(3);
    bus(1, 16'h1200, 0, 0, 0, 0, 0, 0, b);
    chk("R1 exact", b, 1);
    for (int i = 0; i < 16; i++) begin
      bus(1, 16'h1200 ^ 16'(1 << i), 0, 0, 0, 0, 0, 0, b);
      chk("R1 masked bit", b, (16'h00F0 >> i) & 1);
    end
    wr(3'd1, 16'h0); wr(3'd0, 16'h0100); idle(3);

    // R8 sticky flags and clearing
    wr(3'd7, 16'h0); idle(3);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b);
    idle(3);
    rd(3'd7, d, st);
    chk("R8 flag A sticky", d, 1);
    wr(3'd7, 16'h0006); idle(3);
    rd(3'd7, d, st);
    chk("R8 write 1 keeps / write 0 clears", d, 0);
    // R8 clear write applied in the same edge as a hardware match
    wr(3'd7, 16'h0);
    @(negedge clk);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b);
    chk("R8 match brk", b, 1);
    rd(3'd7, d, st);
    chk("R8 clear wins", d & 1, 0);

    // R4 bus select, R5 independent channel B
    wr(3'd3, 16'h0200); wr(3'd5, 16'h003F); idle(3);
    bus(0, 0, 0, 0, 1, 16'h0100, 0, 0, b);
    chk("R4 A ignores internal bus", b, 0);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b);
    chk("R4 A sees ib", b, 1);
    bus(1, 16'h0200, 0, 0, 0, 0, 0, 0, b);
    chk("R4 B ignores ib", b, 0);
    wr(3'd7, 16'h0); idle(3);
    bus(0, 0, 0, 0, 1, 16'h0200, 1, 0, b);
    chk("R5 B alone fires", b, 1);
    rd(3'd7, d, st);
    chk("R5 flag B only", d, 2);
    bus(0, 0, 0, 0, 0, 0, 0, 0, b);
    chk("R5 one cycle pulse", b, 0);
    wr(3'd2, 16'h003F); idle(3);
    bus(0, 0, 0, 0, 1, 16'h0100, 0, 0, b);
    chk("R4 A on internal bus", b, 1);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b);
    chk("R4 A now ignores ib", b, 0);
    wr(3'd2, 16'h003D); idle(3);

    // R9 write delay: bus cycles at E+1 and E+2 use the old address
    wr(3'd0, 16'h0300);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b); chk("R9 E+1 old", b, 1);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b); chk("R9 E+2 old", b, 1);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b); chk("R9 E+3 new", b, 0);
    bus(1, 16'h0300, 0, 0, 0, 0, 0, 0, b); chk("R9 new addr", b, 1);
    wr(3'd0, 16'h0100); idle(3);

    // R10 read stall
    rd(3'd1, d, st);
    chk("R10 no stall idle", st, 0);
    wr(3'd1, 16'h0055);
    rd(3'd1, d, st);
    chk("R10 stall cycles", st, 2);
    chk("R10 updated value", d, 16'h0055);
    wr(3'd1, 16'h0); idle(3);

    // R6 sequential sweep over all 3-cycle patterns
    wr(3'd6, 16'h1); idle(3);
    for (int p = 0; p < 64; p++) begin
      wr(3'd7, 16'h0); idle(3);
      armed = 0;
      for (int s = 0; s < 3; s++) begin
        int sym, fa, fb;
        sym = (p >> (2 * s)) & 3;
        fa = sym & 1; fb = (sym >> 1) & 1;
        bus(fa[0], 16'h0100, 0, 0, fb[0], 16'h0200, 0, 0, b);
        exp = armed & fb;
        if (exp != 0) armed = 0;
        else if (fa != 0) armed = 1;
        chk("R6 sequence", b, exp);
      end
    end

    // R7 armed holds, cleared by software, cleared by mode change
    wr(3'd7, 16'h0); idle(3);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b); chk("R6 A alone no brk", b, 0);
    idle(5);
    rd(3'd7, d, st); chk("R7 armed held", (d >> 2) & 1, 1);
    bus(0, 0, 0, 0, 1, 16'h0200, 0, 0, b); chk("R7 B after hold fires", b, 1);
    rd(3'd7, d, st); chk("R7 fire disarms", (d >> 2) & 1, 0);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b);
    wr(3'd7, 16'h0003); idle(3);
    rd(3'd7, d, st); chk("R7 sw clear armed", (d >> 2) & 1, 0);
    chk("R8 flags kept by write 1", d & 3, 3);
    bus(0, 0, 0, 0, 1, 16'h0200, 0, 0, b); chk("R7 no brk after sw clear", b, 0);
    bus(1, 16'h0100, 0, 0, 0, 0, 0, 0, b);
    wr(3'd6, 16'h0); wr(3'd6, 16'h1); idle(3);
    bus(0, 0, 0, 0, 1, 16'h0200, 0, 0, b); chk("R7 mode change disarms", b, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule